// File: doc/BRIEF.md
# Dual-Buffer Serial Page Write Front-End

This block is the device side of a serial page-flash write path. A host on the SPI pins (chip select, serial clock, serial data in, serial data out; clock modes 0 and 3) sends a one-byte command and then a 24-bit address. It can then send any number of data bytes. The block decodes two program commands, each tied to one of two 528-byte page buffers. It streams the data bytes into the chosen buffer. When chip select is released, it commits that buffer to one page of a small on-chip array model. The commit first fills the page with all ones and then copies the full buffer into it. The `busy` pin stays high for a fixed, parameterised number of system-clock cycles during the commit.

All SPI pins are sampled into the system-clock domain through a synchronizer. The serial clock must therefore run at well under a quarter of the system clock. A status command can be issued at any time and returns one byte with a ready flag. Every other command is ignored while the commit runs. The array model has a read stream so that its contents can be inspected. `rd_valid`/`rd_ready` form the request handshake. `rd_ready` is low for as long as `busy` is high, and that is the only back-pressure. Responses carry no ready signal: the consumer must take `rd_data` whenever `rd_data_valid` is high.

Top module: `pgw_front`

## Requirements
- R1: Command byte 82h selects buffer 0 and 85h selects buffer 1. Any command byte other than these two and the status byte 57h ignores the rest of the frame. It writes no buffer and starts no commit.
- R2: The 24 address bits after the command byte are sent MSB first. Bits 23:22 are ignored. Bits 21:10 give the page number, and the array model uses the page number modulo ARRAY_PAGES. Bits 9:0 give the starting byte position.
- R3: Each complete data byte goes to the next buffer position, starting from the given one. After position 527 the next position is 0. A start position of 528 or above is treated as 0.
- R4: When chip select rises after a complete address, the chosen page is erased to FFh and then loaded with all 528 bytes of the chosen buffer. This includes buffer bytes written by earlier commands and left untouched by this one.
- R5: `busy` goes high within a few cycles of the chip-select rise. It stays high for exactly max(PROG_CYCLES, 1057) system-clock cycles.
- R6: A chip-select rise before all 32 command and address bits have arrived starts no commit, leaves `busy` low and changes no page.
- R7: Bits of an incomplete final data byte are discarded.
- R8: A program command that begins while `busy` is high writes nothing into either buffer and starts no commit.
- R9: After command byte 57h, `spi_miso` shifts out a status byte MSB first. It changes after each falling serial clock edge. Bit 7 is 1 when ready and 0 when busy, and bits 6:0 are 0. The byte repeats every 8 clocks and is re-sampled each time. Outside a status read, `spi_miso` is 0.
- R10: Commands work the same whether the serial clock idles low (mode 0) or high (mode 3).
- R11: `rd_ready` is the inverse of `busy`. A request accepted on one edge returns `rd_data` with `rd_data_valid` on the next edge. A byte position of 528 or above returns FFh.
- R12: During and after reset, `busy`, `spi_miso` and `rd_data_valid` are 0 and `rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 or 3 |
| spi_mosi | input | 1 | SPI serial data into the block |
| spi_miso | output | 1 | SPI serial data out (status) |
| busy | output | 1 | High while a page commit runs |
| rd_valid | input | 1 | Array read request valid |
| rd_ready | output | 1 | Array read request accepted when high |
| rd_page | input | PAGE_FIELD_W | Page number of the read |
| rd_byte | input | BYTE_FIELD_W | Byte position of the read |
| rd_data_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response byte |

## Verification
A slip in the bit counter or in the decode state shows up at the next chip-select rise. Either `busy` fails to rise, or the page read back afterwards has its bytes shifted or placed in the wrong page. A bad buffer pointer or wrap shows up only after the commit, when the read stream returns a byte at the wrong position. Errors in the commit counter show up at once in the length of the `busy` pulse. A stale status sample shows up within one byte of serial clocks on `spi_miso`.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int NBUF = 2;
  localparam logic [7:0] OPC_PROG_B0 = 8'h82;
  localparam logic [7:0] OPC_PROG_B1 = 8'h85;
  localparam logic [7:0] OPC_STATUS  = 8'h57;
  typedef enum logic [2:0] {
    FE_IDLE, FE_OPC, FE_ADDR, FE_DATA, FE_STAT, FE_SKIP
  } fe_state_t;
endpackage

// File: rtl/pgw_spi_sync.sv
module pgw_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES:0] cs_p, sck_p, si_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      si_p  <= '0;
    end else begin
      cs_p  <= {cs_p[STAGES-1:0], cs_n_i};
      sck_p <= {sck_p[STAGES-1:0], sck_i};
      si_p  <= {si_p[STAGES-1:0], mosi_i};
    end
  end

  // Edge strobes compare the newest synchronized sample with the one before.
  assign cs_fall  =  cs_p[STAGES]  & ~cs_p[STAGES-1];
  assign cs_rise  = ~cs_p[STAGES]  &  cs_p[STAGES-1];
  assign sck_rise = ~sck_p[STAGES] &  sck_p[STAGES-1];
  assign sck_fall =  sck_p[STAGES] & ~sck_p[STAGES-1];
  assign mosi_s   =  si_p[STAGES-1];
endmodule

// File: rtl/pgw_ram.sv
module pgw_ram #(
  parameter int DEPTH = 528,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgw_cmd_fsm.sv
module pgw_cmd_fsm
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES   = 528,
  parameter int PAGE_FIELD_W = 12,
  parameter int BYTE_FIELD_W = 10,
  localparam int BYTE_W      = $clog2(PAGE_BYTES),
  localparam int ADDR_W      = 2 + PAGE_FIELD_W + BYTE_FIELD_W,
  localparam int CNT_W       = $clog2(ADDR_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_fall,
  input  logic                    cs_rise,
  input  logic                    sck_rise,
  input  logic                    sck_fall,
  input  logic                    mosi_bit,
  input  logic                    busy,
  output logic                    buf_we,
  output logic                    buf_sel,
  output logic [BYTE_W-1:0]       buf_waddr,
  output logic [7:0]              buf_wdata,
  output logic                    launch,
  output logic [PAGE_FIELD_W-1:0] launch_page,
  output logic                    miso
);
  localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_W - 1);
  localparam logic [BYTE_W-1:0] LAST_POS     = BYTE_W'(PAGE_BYTES - 1);

  fe_state_t                st;
  logic [ADDR_W-1:0]        sh, next_sh;
  logic [CNT_W-1:0]         cnt;
  logic [BYTE_W-1:0]        ptr;
  logic [2:0]               sidx;
  logic [BYTE_FIELD_W-1:0]  start_f;
  logic [7:0]               opc_w;

  always_comb begin
    next_sh = {sh[ADDR_W-2:0], mosi_bit};
    start_f = next_sh[BYTE_FIELD_W-1:0];
    opc_w   = next_sh[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= FE_IDLE;
      sh          <= '0;
      cnt         <= '0;
      ptr         <= '0;
      sidx        <= '0;
      buf_we      <= 1'b0;
      buf_sel     <= 1'b0;
      buf_waddr   <= '0;
      buf_wdata   <= '0;
      launch      <= 1'b0;
      launch_page <= '0;
      miso        <= 1'b0;
    end else begin
      buf_we <= 1'b0;
      launch <= 1'b0;
      if (cs_fall) begin
        st   <= FE_OPC;
        cnt  <= '0;
        miso <= 1'b0;
      end else if (cs_rise) begin
        // Commit only once the full command and address are in.
        if (st == FE_DATA) launch <= 1'b1;
        st   <= FE_IDLE;
        miso <= 1'b0;
      end else if (sck_rise) begin
        sh  <= next_sh;
        cnt <= cnt + 1'b1;
        case (st)
          FE_OPC: if (cnt == LAST_BYTE_BIT) begin
            cnt <= '0;
            if (opc_w == OPC_STATUS) begin
              st   <= FE_STAT;
              sidx <= '0;
            end else if ((opc_w == OPC_PROG_B0 || opc_w == OPC_PROG_B1) && !busy) begin
              st      <= FE_ADDR;
              buf_sel <= (opc_w == OPC_PROG_B1);
            end else begin
              st <= FE_SKIP;
            end
          end
          FE_ADDR: if (cnt == LAST_ADDR_BIT) begin
            cnt         <= '0;
            st          <= FE_DATA;
            launch_page <= next_sh[BYTE_FIELD_W +: PAGE_FIELD_W];
            ptr         <= (32'(start_f) >= PAGE_BYTES) ? '0 : BYTE_W'(start_f);
          end
          FE_DATA: if (cnt == LAST_BYTE_BIT) begin
            cnt       <= '0;
            buf_we    <= 1'b1;
            buf_waddr <= ptr;
            buf_wdata <= opc_w;
            ptr       <= (ptr == LAST_POS) ? '0 : ptr + 1'b1;
          end
          default: ;
        endcase
      end else if (sck_fall && st == FE_STAT) begin
        // Status is sampled live each time bit 7 goes out.
        miso <= (sidx == 3'd0) ? !busy : 1'b0;
        sidx <= sidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgw_prog_seq.sv
module pgw_prog_seq #(
  parameter int PAGE_BYTES   = 528,
  parameter int ARRAY_PAGES  = 4,
  parameter int PAGE_FIELD_W = 12,
  parameter int PROG_CYCLES  = 1200,
  localparam int BYTE_W      = $clog2(PAGE_BYTES),
  localparam int ARR_DEPTH   = ARRAY_PAGES * PAGE_BYTES,
  localparam int ARR_AW      = $clog2(ARR_DEPTH),
  localparam int RUN         = (PROG_CYCLES < 2*PAGE_BYTES + 1) ? 2*PAGE_BYTES + 1 : PROG_CYCLES,
  localparam int CNT_W       = $clog2(RUN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  logic                    launch_sel,
  input  logic [PAGE_FIELD_W-1:0] launch_page,
  output logic                    busy,
  output logic                    buf_rsel,
  output logic                    buf_re,
  output logic [BYTE_W-1:0]       buf_raddr,
  input  logic [7:0]              buf_rdata,
  output logic                    arr_we,
  output logic [ARR_AW-1:0]       arr_waddr,
  output logic [7:0]              arr_wdata
);
  logic               active, cp_v, in_erase, in_copy;
  logic [CNT_W-1:0]   cnt;
  logic [ARR_AW-1:0]  base;
  logic [BYTE_W-1:0]  cp_off;

  always_comb begin
    in_erase  = active && (32'(cnt) < PAGE_BYTES);
    in_copy   = active && (32'(cnt) >= PAGE_BYTES) && (32'(cnt) < 2*PAGE_BYTES);
    buf_re    = in_copy;
    buf_raddr = BYTE_W'(32'(cnt) - PAGE_BYTES);
    arr_we    = in_erase | cp_v;
    arr_waddr = base + (in_erase ? ARR_AW'(cnt) : ARR_AW'(cp_off));
    arr_wdata = in_erase ? 8'hFF : buf_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt      <= '0;
      base     <= '0;
      buf_rsel <= 1'b0;
      cp_v     <= 1'b0;
      cp_off   <= '0;
    end else begin
      cp_v   <= in_copy;
      cp_off <= buf_raddr;
      if (launch && !active) begin
        active   <= 1'b1;
        cnt      <= '0;
        buf_rsel <= launch_sel;
        base     <= ARR_AW'((32'(launch_page) % ARRAY_PAGES) * PAGE_BYTES);
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (32'(cnt) == RUN - 1) active <= 1'b0;
      end
    end
  end

  assign busy = active;
endmodule

// File: rtl/pgw_front.sv
module pgw_front
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES   = 528,
  parameter int ARRAY_PAGES  = 4,
  parameter int PAGE_FIELD_W = 12,
  parameter int BYTE_FIELD_W = 10,
  parameter int PROG_CYCLES  = 1200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_cs_n,
  input  logic                    spi_sck,
  input  logic                    spi_mosi,
  output logic                    spi_miso,
  output logic                    busy,
  input  logic                    rd_valid,
  output logic                    rd_ready,
  input  logic [PAGE_FIELD_W-1:0] rd_page,
  input  logic [BYTE_FIELD_W-1:0] rd_byte,
  output logic                    rd_data_valid,
  output logic [7:0]              rd_data
);
  localparam int BYTE_W    = $clog2(PAGE_BYTES);
  localparam int ARR_DEPTH = ARRAY_PAGES * PAGE_BYTES;
  localparam int ARR_AW    = $clog2(ARR_DEPTH);

  logic cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;
  logic buf_we, buf_sel, launch, buf_rsel, buf_re, arr_we;
  logic [BYTE_W-1:0] buf_waddr, buf_raddr;
  logic [7:0] buf_wdata, buf_rdata, arr_wdata, arr_rdata;
  logic [7:0] buf_rdata_v [NBUF];
  logic [PAGE_FIELD_W-1:0] launch_page;
  logic [ARR_AW-1:0] arr_waddr, arr_raddr;
  logic rd_fire, rd_in_range, oor_q;

  pgw_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .mosi_i(spi_mosi),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(mosi_s)
  );

  pgw_cmd_fsm #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_FIELD_W(PAGE_FIELD_W), .BYTE_FIELD_W(BYTE_FIELD_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_bit(mosi_s), .busy(busy),
    .buf_we(buf_we), .buf_sel(buf_sel), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .launch(launch), .launch_page(launch_page), .miso(spi_miso)
  );

  pgw_prog_seq #(
    .PAGE_BYTES(PAGE_BYTES), .ARRAY_PAGES(ARRAY_PAGES),
    .PAGE_FIELD_W(PAGE_FIELD_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_sel(buf_sel),
    .launch_page(launch_page), .busy(busy), .buf_rsel(buf_rsel), .buf_re(buf_re),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    pgw_ram #(.DEPTH(PAGE_BYTES), .AW(BYTE_W)) u_buf (
      .clk(clk), .we(buf_we && (buf_sel == 1'(g))), .waddr(buf_waddr), .wdata(buf_wdata),
      .re(buf_re && (buf_rsel == 1'(g))), .raddr(buf_raddr), .rdata(buf_rdata_v[g])
    );
  end

  assign buf_rdata = buf_rdata_v[buf_rsel];

  // Read stream into the array model; stalls only while a commit runs.
  assign rd_ready    = !busy;
  assign rd_fire     = rd_valid && rd_ready;
  assign rd_in_range = 32'(rd_byte) < PAGE_BYTES;
  assign arr_raddr   = ARR_AW'((32'(rd_page) % ARRAY_PAGES) * PAGE_BYTES + 32'(rd_byte));

  pgw_ram #(.DEPTH(ARR_DEPTH), .AW(ARR_AW)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .re(rd_fire && rd_in_range), .raddr(arr_raddr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_valid <= 1'b0;
      oor_q         <= 1'b0;
    end else begin
      rd_data_valid <= rd_fire;
      oor_q         <= !rd_in_range;
    end
  end

  assign rd_data = oor_q ? 8'hFF : arr_rdata;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int PROG_CYCLES = 1200,
  parameter int PAGE_BYTES  = 528,
  localparam int RUN        = (PROG_CYCLES < 2*PAGE_BYTES + 1) ? 2*PAGE_BYTES + 1 : PROG_CYCLES
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic launch,
  input logic buf_we,
  input logic rd_valid,
  input logic rd_ready,
  input logic rd_data_valid
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else        run_len <= busy ? run_len + 1 : 0;
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == RUN));

  p_busy_from_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  p_no_launch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);

  p_no_bufwr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rd_data_valid);

  p_rd_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> !rd_data_valid);
endmodule

bind pgw_front pgw_checker #(.PROG_CYCLES(PROG_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .launch(launch), .buf_we(buf_we),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data_valid(rd_data_valid)
);

// File: tb/tb_pgw_front.sv
module tb_pgw_front;
  localparam int PB   = 528;
  localparam int NPG  = 4;
  localparam int PROG = 1200;
  localparam int RUN  = (PROG < 2*PB + 1) ? 2*PB + 1 : PROG;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic spi_cs_n = 1, spi_sck = 0, spi_mosi = 0;
  logic spi_miso, busy, rd_ready, rd_data_valid;
  logic rd_valid = 0;
  logic [11:0] rd_page = 0;
  logic [9:0]  rd_byte = 0;
  logic [7:0]  rd_data;

  pgw_front #(.ARRAY_PAGES(NPG), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_page(rd_page), .rd_byte(rd_byte), .rd_data_valid(rd_data_valid), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit m3 = 0;
  logic [7:0] bufm [2][PB];
  logic [7:0] arrm [NPG][PB];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int cur_run = 0, last_len = 0, runs = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Busy pulse monitor, independent of the design's counters.
  always @(negedge clk) begin
    if (busy) cur_run++;
    else if (cur_run != 0) begin last_len = cur_run; runs++; cur_run = 0; end
  end

  // Scoreboard monitor for the read stream.
  always @(negedge clk) begin
    if (rd_data_valid) begin
      if (exp_q.size() == 0) chk(0, "R11", int'(rd_data), 0, "unexpected response");
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, int'(rd_data), int'(e), "read data");
      end
    end
  end

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'(seed * 37 + k * 11 + (k >> 4));
  endfunction

  task automatic spi_bit(input logic b);
    @(negedge clk); spi_sck = 0; spi_mosi = b;
    repeat (HALF) @(negedge clk);
    spi_sck = 1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic cs_start();
    @(negedge clk); spi_sck = m3;
    repeat (2) @(negedge clk);
    spi_cs_n = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_end();
    @(negedge clk); if (!m3) spi_sck = 0;
    repeat (4) @(negedge clk);
    spi_cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic prog_frame(input logic [7:0] opc, input int sel, input logic [11:0] page,
                            input int start, input int n, input int seed, input bit accept,
                            input int addr_bits, input int tail_bits);
    logic [23:0] a;
    int p;
    a = {2'b11, page, 10'(start)};
    cs_start();
    send_byte(opc);
    for (int i = 23; i >= 24 - addr_bits; i--) spi_bit(a[i]);
    if (addr_bits == 24) begin
      for (int k = 0; k < n; k++) send_byte(pat(seed, k));
      for (int k = 0; k < tail_bits; k++) spi_bit(k[0]);
    end
    cs_end();
    if (accept && addr_bits == 24) begin
      p = (start >= PB) ? 0 : start;
      for (int k = 0; k < n; k++) begin
        bufm[sel][p] = pat(seed, k);
        p = (p == PB - 1) ? 0 : p + 1;
      end
      for (int k = 0; k < PB; k++) arrm[page % NPG][k] = bufm[sel][k];
    end
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic read_page(input int pg, input string tag);
    for (int b = 0; b < PB; b++) begin
      @(negedge clk);
      rd_valid = 1; rd_page = 12'(pg); rd_byte = 10'(b);
      exp_q.push_back(arrm[pg % NPG][b]);
      tag_q.push_back(tag);
    end
    @(negedge clk); rd_valid = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic status_read(input int nbytes, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    cs_start();
    send_byte(8'h57);
    for (int j = 0; j < nbytes; j++) begin
      for (int i = 7; i >= 0; i--) begin
        @(negedge clk); spi_sck = 0;
        repeat (HALF) @(negedge clk);
        got[i] = spi_miso;
        spi_sck = 1;
        repeat (HALF - 1) @(negedge clk);
      end
      chk(got === exp, tag, int'(got), int'(exp), "status byte");
    end
    cs_end();
  endtask

  initial begin
    #1900000;
    chk(0, "watchdog", 0, 1, "run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(busy === 0 && spi_miso === 0 && rd_data_valid === 0 && rd_ready === 1, "R12",
        {busy, spi_miso, rd_data_valid, rd_ready}, 4'b0001, "outputs in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy === 0 && spi_miso === 0 && rd_data_valid === 0 && rd_ready === 1, "R12",
        {busy, spi_miso, rd_data_valid, rd_ready}, 4'b0001, "outputs after reset");

    // R1/R4/R5: fill buffer 0 in mode 0 and commit to page 0
    m3 = 0;
    prog_frame(8'h82, 0, 12'd0, 0, PB, 3, 1, 24, 0);
    wait_idle();
    chk(runs == 1, "R5", runs, 1, "commit count");
    chk(last_len == RUN, "R5", last_len, RUN, "busy length");
    read_page(0, "R1");

    // R10/R2: buffer 1 in mode 3, page field 805h maps to page 1
    m3 = 1;
    prog_frame(8'h85, 1, 12'h805, 0, PB, 9, 1, 24, 0);
    wait_idle();
    chk(runs == 2, "R10", runs, 2, "mode 3 commit count");
    chk(last_len == RUN, "R5", last_len, RUN, "busy length mode 3");
    read_page(1, "R2");

    // R3/R7: wrap from 526 and a trailing partial byte
    m3 = 0;
    prog_frame(8'h82, 0, 12'd2, 526, 5, 21, 1, 24, 4);
    wait_idle();
    read_page(2, "R3");
    read_page(2, "R7");

    // R3: start position above the buffer maps to 0
    prog_frame(8'h85, 1, 12'd3, 700, 2, 33, 1, 24, 0);
    wait_idle();
    read_page(3, "R3");
    chk(runs == 4, "R4", runs, 4, "commit count after four commands");

    // R6: abort inside the address
    r0 = runs;
    prog_frame(8'h82, 0, 12'd0, 0, 0, 0, 0, 10, 0);
    repeat (20) @(negedge clk);
    chk(runs == r0 && busy === 0, "R6", runs, r0, "aborted frame commit");
    read_page(0, "R6");

    // R1: unknown command with full frame
    prog_frame(8'h83, 0, 12'd0, 0, 6, 44, 0, 24, 0);
    repeat (20) @(negedge clk);
    chk(runs == r0 && busy === 0, "R1", runs, r0, "unknown command commit");
    read_page(0, "R1");

    // R8/R9/R11: activity while busy
    prog_frame(8'h82, 0, 12'd2, 10, 3, 55, 1, 24, 0);
    chk(busy === 1, "R5", busy, 1, "busy after commit start");
    chk(rd_ready === 0, "R11", rd_ready, 0, "ready while busy");
    status_read(2, 8'h00, "R9");
    prog_frame(8'h85, 1, 12'd3, 0, 4, 66, 0, 24, 0);
    chk(busy === 1, "R8", busy, 1, "ignored frame ended inside busy");
    wait_idle();
    chk(runs == r0 + 1, "R8", runs, r0 + 1, "no commit from busy-time command");
    status_read(2, 8'h80, "R9");
    chk(spi_miso === 0, "R9", spi_miso, 0, "miso outside status read");
    // zero-byte commit of buffer 1 exposes whether it was touched
    prog_frame(8'h85, 1, 12'd0, 5, 0, 0, 1, 24, 0);
    wait_idle();
    read_page(0, "R8");
    read_page(2, "R4");

    // R11: out-of-range byte position
    @(negedge clk);
    rd_valid = 1; rd_page = 12'd1; rd_byte = 10'd600;
    exp_q.push_back(8'hFF); tag_q.push_back("R11");
    @(negedge clk); rd_valid = 0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11", exp_q.size(), 0, "responses outstanding");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule